// File: doc/BRIEF.md
# Prioritised Interrupt Level Arbiter

This block decides whether a processor core must take an interrupt trap. It holds a software request register and a current priority level register. Each cycle it combines the software requests with an external request vector. From these it forms a summary word of every pending request and a winning priority level. The external request vector is sampled directly from the input.

An arm flag controls when the decision is acted on. In a cycle where the block is armed and the winning level is above the current level, the block loads the summary and the level into two status registers and raises a trap pulse for one cycle. The arm flag clears after every armed cycle, whether or not a trap was raised. A return-from-handler event sets the flag again.

Software requests at indices 4..18 map to levels 1..15. External requests at indices 20..30 map to a level equal to their own index. The highest pending index always wins, so any external request beats every software request.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, armed is 1, and trapPulse, swReqQ, curLevel, isrQ and intIdQ are all 0.
- R2: A software request write keeps only bits 4 through 18 of swReqWdata. All other bits of swReqQ read as 0.
- R3: A level write stores only bits 4:0 of lvlWdata into curLevel.
- R4: With no external request pending, winLevel equals (i - 3), where i is the highest set bit of swReqQ in the range 4..18. With no request pending at all, winLevel is 0.
- R5: Any external request bit i in the range 20..30 gives winLevel = i for the highest such i, regardless of the software requests.
- R6: extReq bits outside 20..30 have no effect on pendSummary or winLevel.
- R7: pendSummary has a 1 at every index of a pending software request (4..18) and every pending external request (20..30), and 0 at every other index.
- R8: trapPulse is 1 in the cycle after an armed cycle in which winLevel is nonzero and strictly greater than curLevel. It is 0 otherwise, including when the two levels are equal.
- R9: On the edge that raises trapPulse, isrQ takes pendSummary and intIdQ takes winLevel. At all other edges both registers hold their values.
- R10: armed clears after every armed cycle unless rearm is high in that cycle. It becomes 1 on the edge after rearm is high. While the block is disarmed, no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swReqWe | input | 1 | Write strobe for the software request register |
| swReqWdata | input | 32 | Software request write data |
| lvlWe | input | 1 | Write strobe for the current level register |
| lvlWdata | input | 32 | Current level write data |
| extReq | input | 32 | External request vector, indexed by level |
| rearm | input | 1 | Return-from-handler event; arms the next evaluation |
| swReqQ | output | 32 | Software request register |
| curLevel | output | 5 | Current priority level |
| pendSummary | output | 32 | Summary of all pending requests |
| winLevel | output | 5 | Winning pending level |
| armed | output | 1 | Evaluation armed flag |
| trapPulse | output | 1 | One-cycle trap request |
| isrQ | output | 32 | Latched summary at the last trap |
| intIdQ | output | 5 | Latched level at the last trap |

## Verification
Assertions check the following on every cycle:
- the masking of both writes;
- that a trap follows only an armed cycle, with a latched level strictly above the level that was current then;
- that the status registers hold between traps;
- that an armed cycle without rearm leaves the block disarmed;
- that a pending external request pushes the level into the external range.

Only the bench's sweeps can show the exact level mapping of each software and external index, the exclusion of out-of-range external bits, and the exact summary word. The same applies to the strict comparison at every pairing of current and winning level.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

  typedef struct packed {
    logic evalNow;
    logic latchStatus;
  } ctrlStrobes_t;

  function automatic logic [63:0] spanMask(input int lo, input int hi);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irqarb_datapath.sv
module irqarb_datapath
  import irqarb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 5,
  parameter int SW_LO  = 4,
  parameter int SW_HI  = 18,
  parameter int EXT_LO = 20,
  parameter int EXT_HI = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReqWe,
  input  logic [DATA_W-1:0] swReqWdata,
  input  logic              lvlWe,
  input  logic [DATA_W-1:0] lvlWdata,
  input  logic [DATA_W-1:0] extReq,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] swReqQ,
  output logic [LVL_W-1:0]  curLevel,
  output logic [DATA_W-1:0] pendSummary,
  output logic [LVL_W-1:0]  winLevel,
  output logic              fireCond,
  output logic [DATA_W-1:0] isrQ,
  output logic [LVL_W-1:0]  intIdQ
);

  localparam logic [DATA_W-1:0] SW_MASK  = DATA_W'(spanMask(SW_LO, SW_HI));
  localparam logic [DATA_W-1:0] EXT_MASK = DATA_W'(spanMask(EXT_LO, EXT_HI));

  logic [DATA_W-1:0] extLive;
  logic [LVL_W-1:0]  swLevel;
  logic [LVL_W-1:0]  extLevel;
  logic              extHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swReqQ   <= '0;
      curLevel <= '0;
    end else begin
      if (swReqWe) swReqQ <= swReqWdata & SW_MASK;
      if (lvlWe)   curLevel <= lvlWdata[LVL_W-1:0];
    end
  end

  assign extLive = extReq & EXT_MASK;
  assign extHit  = |extLive;

  // ascending scan: a later (higher) hit overwrites an earlier one
  always_comb begin
    swLevel = '0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (swReqQ[i]) swLevel = LVL_W'(i - SW_LO + 1);
    end
  end

  always_comb begin
    extLevel = '0;
    for (int i = EXT_LO; i <= EXT_HI; i++) begin
      if (extLive[i]) extLevel = LVL_W'(i);
    end
  end

  assign winLevel    = extHit ? extLevel : swLevel;
  assign pendSummary = swReqQ | extLive;
  assign fireCond    = (winLevel != '0) && (winLevel > curLevel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isrQ   <= '0;
      intIdQ <= '0;
    end else if (strobes.latchStatus) begin
      isrQ   <= pendSummary;
      intIdQ <= winLevel;
    end
  end

  AST_SWREQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    swReqWe |=> ((swReqQ & ~SW_MASK) == '0)); // R2
  AST_LEVEL_FIT: assert property (@(posedge clk) disable iff (!rstN)
    lvlWe |=> (curLevel == LVL_W'($past(lvlWdata)))); // R3
  AST_EXT_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    extHit |-> (winLevel >= LVL_W'(EXT_LO))); // R5
  AST_SUMMARY_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (winLevel != '0) |-> (pendSummary != '0)); // R7
  AST_LATCH_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchStatus |=> (intIdQ > $past(curLevel))); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchStatus |=> ($stable(isrQ) && $stable(intIdQ))); // R9

endmodule

// File: rtl/irqarb_ctrl.sv
module irqarb_ctrl
  import irqarb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rearm,
  input  logic         fireCond,
  output ctrlStrobes_t strobes,
  output logic         armed,
  output logic         trapPulse
);

  always_comb begin
    strobes.evalNow     = armed;
    strobes.latchStatus = armed && fireCond;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b1;
      trapPulse <= 1'b0;
    end else begin
      if (rearm)                armed <= 1'b1;
      else if (strobes.evalNow) armed <= 1'b0;
      trapPulse <= strobes.latchStatus;
    end
  end

  AST_TRAP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past(armed)); // R10
  AST_DISARM_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !rearm) |=> !armed); // R10
  AST_REARM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    rearm |=> armed); // R10

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irqarb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 5,
  parameter int SW_LO  = 4,
  parameter int SW_HI  = 18,
  parameter int EXT_LO = 20,
  parameter int EXT_HI = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReqWe,
  input  logic [DATA_W-1:0] swReqWdata,
  input  logic              lvlWe,
  input  logic [DATA_W-1:0] lvlWdata,
  input  logic [DATA_W-1:0] extReq,
  input  logic              rearm,
  output logic [DATA_W-1:0] swReqQ,
  output logic [LVL_W-1:0]  curLevel,
  output logic [DATA_W-1:0] pendSummary,
  output logic [LVL_W-1:0]  winLevel,
  output logic              armed,
  output logic              trapPulse,
  output logic [DATA_W-1:0] isrQ,
  output logic [LVL_W-1:0]  intIdQ
);

  ctrlStrobes_t strobes;
  logic         fireCond;

  irqarb_datapath #(
    .DATA_W(DATA_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
    .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .swReqWe(swReqWe), .swReqWdata(swReqWdata),
    .lvlWe(lvlWe), .lvlWdata(lvlWdata),
    .extReq(extReq), .strobes(strobes),
    .swReqQ(swReqQ), .curLevel(curLevel),
    .pendSummary(pendSummary), .winLevel(winLevel),
    .fireCond(fireCond), .isrQ(isrQ), .intIdQ(intIdQ)
  );

  irqarb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rearm(rearm), .fireCond(fireCond),
    .strobes(strobes), .armed(armed), .trapPulse(trapPulse)
  );

endmodule

// File: tb/tb_irq_level_arbiter.sv
`timescale 1ns/1ps
module tb_irq_level_arbiter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swReqWe = 1'b0;
  logic [31:0] swReqWdata = '0;
  logic        lvlWe = 1'b0;
  logic [31:0] lvlWdata = '0;
  logic [31:0] extReq = '0;
  logic        rearm = 1'b0;
  logic [31:0] swReqQ, pendSummary, isrQ;
  logic [4:0]  curLevel, winLevel, intIdQ;
  logic        armed, trapPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] expIsr = '0;
  logic [4:0]  expId  = '0;

  always #2 clk = ~clk;

  irq_level_arbiter dut (
    .clk(clk), .rstN(rstN), .swReqWe(swReqWe), .swReqWdata(swReqWdata),
    .lvlWe(lvlWe), .lvlWdata(lvlWdata), .extReq(extReq), .rearm(rearm),
    .swReqQ(swReqQ), .curLevel(curLevel), .pendSummary(pendSummary),
    .winLevel(winLevel), .armed(armed), .trapPulse(trapPulse),
    .isrQ(isrQ), .intIdQ(intIdQ)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mSummary(input logic [31:0] sw, input logic [31:0] ex);
    logic [31:0] s = '0;
    for (int i = 4; i <= 18; i++) if (sw[i]) s[i] = 1'b1;
    for (int i = 20; i <= 30; i++) if (ex[i]) s[i] = 1'b1;
    return s;
  endfunction

  function automatic logic [4:0] mLevel(input logic [31:0] sw, input logic [31:0] ex);
    int l = 0;
    for (int i = 4; i <= 18; i++) if (sw[i]) l = i - 3;
    for (int i = 20; i <= 30; i++) if (ex[i]) l = i;
    return 5'(l);
  endfunction

  task automatic writeRegs(input logic [31:0] sw, input logic [31:0] lv);
    @(negedge clk);
    swReqWe = 1'b1; swReqWdata = sw; lvlWe = 1'b1; lvlWdata = lv;
    @(negedge clk);
    swReqWe = 1'b0; lvlWe = 1'b0;
  endtask

  // arm, evaluate, and check the trap decision and status latch
  task automatic evalCase(input logic [31:0] sw, input logic [31:0] ex, input logic [31:0] lv);
    logic [4:0] w;
    bit fire;
    writeRegs(sw, lv);
    extReq = ex;
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    check("R10 armed after rearm", 32'(armed), 32'd1);
    w = mLevel(sw, ex);
    fire = (w != 0) && (w > lv[4:0]);
    @(negedge clk);
    check("R8 trap decision", 32'(trapPulse), 32'(fire));
    if (fire) begin expIsr = mSummary(sw, ex); expId = w; end
    check("R9 isr", isrQ, expIsr);
    check("R9 intid", 32'(intIdQ), 32'(expId));
    check("R10 disarmed", 32'(armed), 32'd0);
    @(negedge clk);
    check("R8 single pulse", 32'(trapPulse), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // first edge after reset is an armed evaluation with nothing pending
    check("R1 armed", 32'(armed), 32'd1);
    check("R1 trap", 32'(trapPulse), 32'd0);
    check("R1 swreq", swReqQ, 32'd0);
    check("R1 level", 32'(curLevel), 32'd0);
    check("R1 isr", isrQ, 32'd0);
    check("R1 intid", 32'(intIdQ), 32'd0);
    @(negedge clk);

    // software single-bit sweep
    for (int b = 0; b < 32; b++) begin
      writeRegs(32'h1 << b, 32'd0);
      check("R2 sw mask", swReqQ, (32'h1 << b) & 32'h0007FFF0);
      check("R4 sw level", 32'(winLevel), 32'(mLevel(32'h1 << b, 32'd0)));
      check("R7 sw summary", pendSummary, mSummary(32'h1 << b, 32'd0));
    end
    writeRegs(32'hFFFFFFFF, 32'd0);
    check("R2 all ones", swReqQ, 32'h0007FFF0);
    check("R4 top sw level", 32'(winLevel), 32'd15);

    // external single-bit sweep over a software background
    writeRegs(32'h00010110, 32'd0);
    for (int b = 0; b < 32; b++) begin
      @(negedge clk);
      extReq = 32'h1 << b;
      #1;
      check("R5 R6 ext level", 32'(winLevel), 32'(mLevel(32'h00010110, 32'h1 << b)));
      check("R6 R7 ext summary", pendSummary, mSummary(32'h00010110, 32'h1 << b));
    end
    extReq = 32'hFFFFFFFF;
    #1;
    check("R5 top ext", 32'(winLevel), 32'd30);
    check("R6 out of range", pendSummary, 32'h7FF10110);
    extReq = '0;

    // level register masking
    writeRegs(32'd0, 32'hFFFFFFE5);
    check("R3 level mask", 32'(curLevel), 32'd5);
    writeRegs(32'd0, 32'h000000A0);
    check("R3 level zero", 32'(curLevel), 32'd0);

    // trap sweep: every current level against four winning levels
    for (int lv = 0; lv < 32; lv++) begin
      evalCase(32'h00000010, 32'd0, 32'(lv));
      evalCase(32'h00040010, 32'd0, 32'(lv));
      evalCase(32'h00000100, 32'h00100000, 32'(lv));
      evalCase(32'h00040000, 32'h40000000, 32'(lv));
    end
    evalCase(32'd0, 32'd0, 32'd0);

    // disarmed: firing condition present but no rearm
    writeRegs(32'h00040000, 32'd0);
    extReq = 32'h40000000;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10 no trap when disarmed", 32'(trapPulse), 32'd0);
      check("R9 hold while disarmed", 32'(intIdQ), 32'(expId));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule